// File: doc/BRIEF.md
# Split-Operand SHA-512 Big-Sigma-0 Execute Unit

This unit sits in the execute stage of a 32-bit RISC-V integer core. It decodes one R-type instruction word and, in parallel, computes one 32-bit half of the SHA-512 big-sigma-0 function. The 64-bit value the function acts on is held in two 32-bit integer registers, and the unit reads both. The function is S(x) = ROTR(x,28) XOR ROTR(x,34) XOR ROTR(x,39). The unit returns only one half of S(x). Software issues the instruction twice with the two source registers swapped, then joins the two results into the full 64-bit value.

The outputs are a match flag, the three register indices taken from the instruction word, and the 32-bit result. With the default setting, every output passes through one register stage, so all outputs appear exactly one clock edge after their inputs, whatever the operand values. A parameter can remove that stage and make the unit purely combinational. The register file, pipeline control and the other SHA-512 operations are outside this block.

Top module: `s512s0_unit`

## Requirements
- R1: Instruction bit fields are funct7 = [31:25], rs2 = [24:20], rs1 = [19:15], funct3 = [14:12], rd = [11:7], opcode = [6:0]. `match_o` is 1 when opcode = 7'b0110011, funct3 = 3'b100 and funct7 = 7'b0101000.
- R2: When any one of opcode, funct3 or funct7 differs from those values, `match_o` is 0.
- R3: `rd_o`, `rs1_idx_o` and `rs2_idx_o` always equal bits [11:7], [19:15] and [24:20] of the instruction, whether or not it matches.
- R4: With the low word of x on `rs1_val_i` and the high word on `rs2_val_i`, `result_o` equals S(x)[31:0].
- R5: With the high word on `rs1_val_i` and the low word on `rs2_val_i`, `result_o` equals S(x)[63:32].
- R6: Joining the result of the swapped run (as the upper word) with the result of the unswapped run (as the lower word) gives the full 64-bit S(x) for any x.
- R7: `result_o` depends only on the two source values. It is not gated by `match_o` and is computed for non-matching words too.
- R8: Both sources zero give a result of 0. Both sources all ones give a result of all ones.
- R9: With LATENCY = 1, every output reflects the inputs present at the previous rising clock edge and keeps its old value until that edge, independent of the operand values.
- R10: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 32 | Instruction word |
| rs1_val_i | input | 32 | Value of the first source register |
| rs2_val_i | input | 32 | Value of the second source register |
| match_o | output | 1 | Instruction is the split big-sigma-0 operation |
| rd_o | output | 5 | Destination register index |
| rs1_idx_o | output | 5 | First source register index |
| rs2_idx_o | output | 5 | Second source register index |
| result_o | output | 32 | One half of the 64-bit big-sigma-0 value |

## Verification
Every output, including the decode flag, the indices and the result, is due exactly one rising edge after its inputs are applied. The bench drives the inputs on the falling edge. It then checks that the result still shows the earlier value just before the next rising edge. One nanosecond after that edge it compares all outputs with a reference built from a 64-bit rotate model. Each operand is run in both source orders, and the two halves are joined and checked against the full 64-bit value.

// File: rtl/s512s0_pkg.sv
`timescale 1ns/1ps
package s512s0_pkg;
   localparam int WORD_W  = 32;
   localparam int INSTR_W = 32;
   localparam int IDX_W   = 5;

   localparam logic [6:0] OPC_ARITH = 7'b0110011;
   localparam logic [2:0] F3_SIGMA  = 3'b100;
   localparam logic [6:0] F7_SIGMA  = 7'b0101000;

   // field order follows bit position, most significant first
   typedef struct packed {
      logic [6:0]       f7;
      logic [IDX_W-1:0] src_b;
      logic [IDX_W-1:0] src_a;
      logic [2:0]       f3;
      logic [IDX_W-1:0] dst;
      logic [6:0]       opc;
   } rtype_t;

   typedef struct packed {
      logic              hit;
      logic [IDX_W-1:0]  dst;
      logic [IDX_W-1:0]  src_a;
      logic [IDX_W-1:0]  src_b;
      logic [WORD_W-1:0] value;
   } outbus_t;
endpackage

// File: rtl/s512s0_decode.sv
`timescale 1ns/1ps
module s512s0_decode
   import s512s0_pkg::*;
(
   input  logic [INSTR_W-1:0] instr_i,
   output logic               hit_o,
   output logic [IDX_W-1:0]   dst_o,
   output logic [IDX_W-1:0]   src_a_o,
   output logic [IDX_W-1:0]   src_b_o
);
   rtype_t fld;
   logic   opc_ok, f3_ok, f7_ok;

   assign fld    = rtype_t'(instr_i);
   assign opc_ok = (fld.opc == OPC_ARITH);
   assign f3_ok  = (fld.f3  == F3_SIGMA);
   assign f7_ok  = (fld.f7  == F7_SIGMA);

   assign hit_o   = opc_ok & f3_ok & f7_ok;
   assign dst_o   = fld.dst;
   assign src_a_o = fld.src_a;
   assign src_b_o = fld.src_b;
endmodule

// File: rtl/s512s0_half_rot.sv
`timescale 1ns/1ps
// One half of a double-width rotate right.
// own_i is the half whose position is reported, other_i the partner half.
module s512s0_half_rot #(
   parameter int W   = 32,
   parameter int ROT = 28
) (
   input  logic [W-1:0] own_i,
   input  logic [W-1:0] other_i,
   output logic [W-1:0] half_o
);
   localparam bit WRAP = (ROT >= W);
   localparam int SH   = WRAP ? ROT - W : ROT;
   localparam int CO   = W - SH;

   generate
      if (SH == 0) begin : g_whole
         if (WRAP) begin : g_swap
            assign half_o = other_i;
         end else begin : g_keep
            assign half_o = own_i;
         end
      end else if (!WRAP) begin : g_near
         assign half_o = (own_i >> SH) | (other_i << CO);
      end else begin : g_far
         assign half_o = (other_i >> SH) | (own_i << CO);
      end
   endgenerate
endmodule

// File: rtl/s512s0_half_sigma.sv
`timescale 1ns/1ps
module s512s0_half_sigma #(
   parameter int W     = 32,
   parameter int ROT_A = 28,
   parameter int ROT_B = 34,
   parameter int ROT_C = 39
) (
   input  logic [W-1:0] own_i,
   input  logic [W-1:0] other_i,
   output logic [W-1:0] half_o
);
   localparam int NTERM = 3;

   logic [W-1:0] term [NTERM];

   generate
      for (genvar g = 0; g < NTERM; g++) begin : g_term
         localparam int AMT = (g == 0) ? ROT_A : ((g == 1) ? ROT_B : ROT_C);
         s512s0_half_rot #(.W(W), .ROT(AMT)) u_rot (
            .own_i   (own_i),
            .other_i (other_i),
            .half_o  (term[g])
         );
      end
   endgenerate

   always_comb begin
      half_o = '0;
      for (int i = 0; i < NTERM; i++) begin
         half_o = half_o ^ term[i];
      end
   end
endmodule

// File: rtl/s512s0_stage.sv
`timescale 1ns/1ps
module s512s0_stage #(
   parameter int W       = 48,
   parameter int LATENCY = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (LATENCY == 0) begin : g_comb
         assign q_o = d_i;
      end else begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q_o <= '0;
            else        q_o <= d_i;
         end
      end
   endgenerate
endmodule

// File: rtl/s512s0_unit.sv
`timescale 1ns/1ps
module s512s0_unit
   import s512s0_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int ROT_A   = 28,
   parameter int ROT_B   = 34,
   parameter int ROT_C   = 39,
   parameter int LATENCY = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [31:0]       instr_i,
   input  logic [XLEN-1:0]   rs1_val_i,
   input  logic [XLEN-1:0]   rs2_val_i,
   output logic              match_o,
   output logic [4:0]        rd_o,
   output logic [4:0]        rs1_idx_o,
   output logic [4:0]        rs2_idx_o,
   output logic [XLEN-1:0]   result_o
);
   localparam int DBL_W = 2 * XLEN;
   localparam int BUS_W = $bits(outbus_t);

   generate
      if (XLEN != WORD_W) begin : g_bad_xlen
         $error("s512s0_unit: XLEN must equal the package word width");
      end
      if (ROT_A < 1 || ROT_A >= DBL_W || ROT_B < 1 || ROT_B >= DBL_W ||
          ROT_C < 1 || ROT_C >= DBL_W) begin : g_bad_rot
         $error("s512s0_unit: rotate amounts must lie in 1 .. 2*XLEN-1");
      end
      if (LATENCY < 0 || LATENCY > 1) begin : g_bad_lat
         $error("s512s0_unit: LATENCY must be 0 or 1");
      end
   endgenerate

   outbus_t nxt, cur;

   s512s0_decode u_dec (
      .instr_i (instr_i),
      .hit_o   (nxt.hit),
      .dst_o   (nxt.dst),
      .src_a_o (nxt.src_a),
      .src_b_o (nxt.src_b)
   );

   s512s0_half_sigma #(
      .W(XLEN), .ROT_A(ROT_A), .ROT_B(ROT_B), .ROT_C(ROT_C)
   ) u_sig (
      .own_i   (rs1_val_i),
      .other_i (rs2_val_i),
      .half_o  (nxt.value)
   );

   s512s0_stage #(.W(BUS_W), .LATENCY(LATENCY)) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (nxt),
      .q_o   (cur)
   );

   assign match_o   = cur.hit;
   assign rd_o      = cur.dst;
   assign rs1_idx_o = cur.src_a;
   assign rs2_idx_o = cur.src_b;
   assign result_o  = cur.value;
endmodule

// File: rtl/s512s0_unit_chk.sv
`timescale 1ns/1ps
module s512s0_unit_chk #(
   parameter int XLEN    = 32,
   parameter int LATENCY = 1
) (
   input logic            clk,
   input logic            rst_n,
   input logic [31:0]     instr_i,
   input logic [XLEN-1:0] rs1_val_i,
   input logic [XLEN-1:0] rs2_val_i,
   input logic            match_o,
   input logic [4:0]      rd_o,
   input logic [4:0]      rs1_idx_o,
   input logic [4:0]      rs2_idx_o,
   input logic [XLEN-1:0] result_o
);
   logic            primed;
   logic [31:0]     seen_ins;
   logic [XLEN-1:0] seen_a, seen_b;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) primed <= 1'b0;
      else        primed <= 1'b1;
   end

   generate
      if (LATENCY == 0) begin : g_now
         assign seen_ins = instr_i;
         assign seen_a   = rs1_val_i;
         assign seen_b   = rs2_val_i;
      end else begin : g_late
         always_ff @(posedge clk) begin
            seen_ins <= instr_i;
            seen_a   <= rs1_val_i;
            seen_b   <= rs2_val_i;
         end
      end
   endgenerate

   AST_MATCH_ENCODING: assert property (@(posedge clk) disable iff (!rst_n || !primed)
      (seen_ins[6:0] == 7'b0110011 && seen_ins[14:12] == 3'b100 &&
       seen_ins[31:25] == 7'b0101000) |-> match_o); // R1

   AST_MISMATCH_LOW: assert property (@(posedge clk) disable iff (!rst_n || !primed)
      (seen_ins[6:0] != 7'b0110011 || seen_ins[14:12] != 3'b100 ||
       seen_ins[31:25] != 7'b0101000) |-> !match_o); // R2

   AST_FIELD_COPY: assert property (@(posedge clk) disable iff (!rst_n || !primed)
      (rd_o == seen_ins[11:7] && rs1_idx_o == seen_ins[19:15] &&
       rs2_idx_o == seen_ins[24:20])); // R3

   AST_ZERO_IN: assert property (@(posedge clk) disable iff (!rst_n || !primed)
      (seen_a == '0 && seen_b == '0) |-> (result_o == '0)); // R8

   AST_ONES_IN: assert property (@(posedge clk) disable iff (!rst_n || !primed)
      (&seen_a && &seen_b) |-> (&result_o)); // R8
endmodule

bind s512s0_unit s512s0_unit_chk #(.XLEN(XLEN), .LATENCY(LATENCY)) u_chk (
   .clk(clk), .rst_n(rst_n), .instr_i(instr_i),
   .rs1_val_i(rs1_val_i), .rs2_val_i(rs2_val_i),
   .match_o(match_o), .rd_o(rd_o), .rs1_idx_o(rs1_idx_o),
   .rs2_idx_o(rs2_idx_o), .result_o(result_o)
);

// File: tb/s512s0_unit_test.sv
`timescale 1ns/1ps
module s512s0_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] instr = '0, va = '0, vb = '0;
   logic        match_o;
   logic [4:0]  rd_o, rs1_idx_o, rs2_idx_o;
   logic [31:0] result_o;

   int n_run = 0, n_fail = 0;
   logic [31:0] prev_res = '0;

   typedef struct {
      logic        m;
      logic [4:0]  rd, r1, r2;
      logic [31:0] res;
   } exp_t;
   exp_t q[$];

   always #2 clk = ~clk;

   s512s0_unit uut (
      .clk(clk), .rst_n(rst_n), .instr_i(instr),
      .rs1_val_i(va), .rs2_val_i(vb),
      .match_o(match_o), .rd_o(rd_o), .rs1_idx_o(rs1_idx_o),
      .rs2_idx_o(rs2_idx_o), .result_o(result_o)
   );

   function automatic logic [63:0] ror64(logic [63:0] x, int r);
      return (x >> r) | (x << (64 - r));
   endfunction

   function automatic logic [63:0] big_sigma0(logic [63:0] x);
      return ror64(x, 28) ^ ror64(x, 34) ^ ror64(x, 39);
   endfunction

   function automatic logic [31:0] enc(logic [6:0] f7, logic [2:0] f3, logic [6:0] opc,
                                       logic [4:0] rd, logic [4:0] r1, logic [4:0] r2);
      return {f7, r2, r1, f3, rd, opc};
   endfunction

   task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   // drive one operation, check all outputs one edge later
   task automatic step(logic [31:0] ins, logic [31:0] a, logic [31:0] b,
                       string rtag, output logic [31:0] got);
      exp_t e, o;
      logic [63:0] full;
      @(negedge clk);
      instr = ins; va = a; vb = b;
      full  = big_sigma0({b, a});
      e.m   = (ins[6:0] == 7'b0110011) && (ins[14:12] == 3'b100) &&
              (ins[31:25] == 7'b0101000);
      e.rd  = ins[11:7]; e.r1 = ins[19:15]; e.r2 = ins[24:20];
      e.res = full[31:0];
      q.push_back(e);
      #1;
      if (e.res != prev_res)
         check(result_o == prev_res, "R9 result held until edge", result_o, prev_res);
      @(posedge clk);
      #1;
      o = q.pop_front();
      check(match_o == o.m, o.m ? "R1 match" : "R2 no match", match_o, o.m);
      check(rd_o == o.rd && rs1_idx_o == o.r1 && rs2_idx_o == o.r2, "R3 indices",
            {rd_o, rs1_idx_o, rs2_idx_o}, {o.rd, o.r1, o.r2});
      check(result_o == o.res, rtag, result_o, o.res);
      got = result_o;
      prev_res = result_o;
   endtask

   task automatic pair(logic [63:0] x, string tag);
      logic [31:0] lo, hi, rd_sel;
      logic [63:0] full;
      rd_sel = $urandom;
      step(enc(7'b0101000, 3'b100, 7'b0110011, rd_sel[4:0], rd_sel[9:5], rd_sel[14:10]),
           x[31:0], x[63:32], "R4 low half", lo);
      step(enc(7'b0101000, 3'b100, 7'b0110011, rd_sel[4:0], rd_sel[14:10], rd_sel[9:5]),
           x[63:32], x[31:0], "R5 high half", hi);
      full = big_sigma0(x);
      check({hi, lo} == full, {"R6 joined halves ", tag}, {hi, lo}, full);
   endtask

   initial begin
      #(4 * 200000);
      n_run++; n_fail++;
      $display("FAIL R9 watchdog expired actual=hung expected=done");
      summary();
   end

   initial begin
      logic [31:0] g;
      logic [63:0] x;
      // R10: outputs zero while in reset, even with live inputs
      instr = enc(7'b0101000, 3'b100, 7'b0110011, 5'd3, 5'd4, 5'd5);
      va = '1; vb = '1;
      repeat (3) @(posedge clk);
      #1;
      check(match_o == 1'b0 && rd_o == '0 && rs1_idx_o == '0 && rs2_idx_o == '0,
            "R10 reset decode outputs", {match_o, rd_o, rs1_idx_o, rs2_idx_o}, 64'd0);
      check(result_o == '0, "R10 reset result", result_o, 64'd0);
      @(negedge clk);
      instr = '0; va = '0; vb = '0;
      rst_n = 1'b1;
      @(posedge clk); #1;
      prev_res = result_o;

      // R8: boundary operands
      pair(64'd0, "R8 zero");
      pair({64{1'b1}}, "R8 ones");
      step(enc(7'b0101000, 3'b100, 7'b0110011, 5'd1, 5'd2, 5'd3), '0, '0, "R8 zero", g);
      step(enc(7'b0101000, 3'b100, 7'b0110011, 5'd1, 5'd2, 5'd3), '1, '1, "R8 ones", g);

      // single set bits across the word boundary
      for (int k = 0; k < 64; k += 7) begin
         x = 64'd1 << k;
         pair(x, "walking bit");
      end
      pair(64'h8000_0000_0000_0001, "edge bits");
      pair(64'h0000_0001_8000_0000, "middle bits");

      // random operands
      for (int n = 0; n < 40; n++) begin
         x = {$urandom, $urandom};
         pair(x, "random");
      end

      // R2 and R7: other funct3 values, result still produced
      for (int f = 0; f < 8; f++) begin
         if (f != 4)
            step(enc(7'b0101000, 3'(f), 7'b0110011, 5'($urandom), 5'($urandom), 5'($urandom)),
                 $urandom, $urandom, "R7 result without match", g);
      end
      // R2: single-bit changes in funct7 and opcode
      for (int b = 0; b < 7; b++) begin
         step(enc(7'b0101000 ^ (7'd1 << b), 3'b100, 7'b0110011, 5'd31, 5'd0, 5'd17),
              $urandom, $urandom, "R7 result without match", g);
         step(enc(7'b0101000, 3'b100, 7'b0110011 ^ (7'd1 << b), 5'd0, 5'd31, 5'd9),
              $urandom, $urandom, "R7 result without match", g);
      end
      // R3: extreme index values on a matching word
      step(enc(7'b0101000, 3'b100, 7'b0110011, 5'd31, 5'd31, 5'd31), 32'h1234_5678,
           32'h9abc_def0, "R4 low half", g);
      step(enc(7'b0101000, 3'b100, 7'b0110011, 5'd0, 5'd0, 5'd0), 32'h9abc_def0,
           32'h1234_5678, "R5 high half", g);
      // zero instruction word
      step(32'd0, 32'hdead_beef, 32'h0bad_f00d, "R7 result without match", g);

      summary();
   end
endmodule